// File: doc/BRIEF.md
# Paged Memory Address Mapper

This block sits between the CPU of an 8-bit home computer and its memories. Each CPU address, 16 bits wide, is resolved combinationally into a target, an offset inside that target, and a write permission. The target is one of internal RAM, the system ROM, two external ROM windows, the I/O area, or no target at all. A 4-bit page register holds the active mapping mode. Software loads it through a one-cycle write strobe.

The address space is cut into thirteen regions of unequal size. Each region picks, from the current mode, one of four mappings:
- an identity RAM mapping;
- a RAM mapping with the two 32 KiB halves swapped;
- a system ROM image at a fixed offset;
- one of the two ROM windows at a fixed offset.

Writes are allowed only where RAM is selected. The memory arrays, the window contents and the I/O decoding are outside the block.

Top module: `page_mapper`

## Requirements
- R1: After reset the mode is 0. In mode 0, addresses 0000-07FF select system ROM at offset equal to the address, with writes disabled. In every other mode except 7 that range is identity RAM.
- R2: A write strobe loads page_data_i into the mode at the clock edge. Mapping outputs follow the new mode from the cycle after the strobe. Without a strobe the mode holds.
- R3: Any region and mode not covered by R1 and R4 to R12 selects RAM with offset equal to the address and writes enabled. This applies to every region below D800 in modes 2, 3 and 11 to 15.
- R4: In mode 7, every address below D800 selects RAM at offset address XOR 0x8000.
- R5: In modes 6 and 8, A000-BFFF selects system ROM at offset address−0x8000. This is the program interpreter image at 0x2000 to 0x3FFF.
- R6: Window 2 mappings:
  - modes 5 and 10: 8000-9FFF at offset address−0x8000, and A000-B7FF at offset address−0xA000;
  - modes 4, 5 and 10: B800-BFFF at offset address−0xA000;
  - modes 8 and 9: C800-D7FF at offset address−0xC800.
- R7: Window 1 mappings:
  - mode 10: 4000-5FFF at offset address−0x4000;
  - modes 8 and 9: 8000-9FFF at offset address−0x8000.
- R8: System ROM mappings:
  - modes 8 and 10: C000-C7FF at offset address−0xC000;
  - mode 10: C800-CFFF at offset address−0xC000.
- R9: E000-E7FF selects system ROM at offset address−0xE000 in mode 1. In every other mode it selects window 1 at the same offset.
- R10: E800-FFFF selects window 1 in modes 3, 4 and 5, and system ROM in every other mode, at offset address−0xE000 in both cases. Writes to E000-FFFF are never enabled.
- R11: DC00-DDFF selects the I/O area at offset address−0xDC00, with writes disabled, in every mode.
- R12: D800-DBFF and DE00-DFFF select no target, with offset 0 and writes disabled.
- R13: Target codes are none=0, RAM=1, system ROM=2, window 1=3, window 2=4 and I/O=5. wr_en_o is 1 exactly when the target is RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| page_we_i | input | 1 | Page register write strobe |
| page_data_i | input | 4 | New mode value |
| addr_i | input | 16 | CPU address |
| tgt_o | output | 3 | Selected target code |
| offset_o | output | 16 | Offset inside the selected target |
| wr_en_o | output | 1 | Write permitted to the target |

## Verification
Target, offset and write permission are combinational from the address, so they are due within the cycle the address is applied. The bench applies each address just after a rising edge and compares at the following falling edge. A page write counts only at the rising edge that samples the strobe. The bench model therefore updates its own mode at that edge, which checks both that the cycle carrying the strobe still uses the old mode and that the next cycle uses the new one. Every mode is swept over the lower and upper bound of every region and gap, with a few interior addresses added.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;
  localparam int ADDR_W   = 16;
  localparam int MODE_W   = 4;
  localparam int NUM_REG  = 13;
  localparam int REG_IDX_W = $clog2(NUM_REG);

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_RAM    = 3'd1,
    TGT_SYSROM = 3'd2,
    TGT_WIN1   = 3'd3,
    TGT_WIN2   = 3'd4,
    TGT_IO     = 3'd5
  } tgt_e;

  // region index -> first address
  function automatic logic [ADDR_W-1:0] reg_lo(input int idx);
    case (idx)
      0:  return 16'h0000;
      1:  return 16'h0800;
      2:  return 16'h4000;
      3:  return 16'h6000;
      4:  return 16'h8000;
      5:  return 16'hA000;
      6:  return 16'hB800;
      7:  return 16'hC000;
      8:  return 16'hC800;
      9:  return 16'hD000;
      10: return 16'hDC00;
      11: return 16'hE000;
      default: return 16'hE800;
    endcase
  endfunction

  // region index -> last address
  function automatic logic [ADDR_W-1:0] reg_hi(input int idx);
    case (idx)
      0:  return 16'h07FF;
      1:  return 16'h3FFF;
      2:  return 16'h5FFF;
      3:  return 16'h7FFF;
      4:  return 16'h9FFF;
      5:  return 16'hB7FF;
      6:  return 16'hBFFF;
      7:  return 16'hC7FF;
      8:  return 16'hCFFF;
      9:  return 16'hD7FF;
      10: return 16'hDDFF;
      11: return 16'hE7FF;
      default: return 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/page_reg.sv
module page_reg #(
  parameter int MODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] data_i,
  output logic [MODE_W-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_o <= '0;
    else if (we_i) mode_o <= data_i;
  end
endmodule

// File: rtl/region_decode.sv
module region_decode
  import page_mapper_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int NREG  = NUM_REG,
  parameter int IDX_W = REG_IDX_W
) (
  input  logic [AW-1:0]    addr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [AW-1:0]    local_o
);
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    localparam logic [AW-1:0] LO   = reg_lo(g);
    localparam logic [AW-1:0] SPAN = reg_hi(g) - reg_lo(g);
    logic [AW-1:0] rel;
    assign rel    = addr_i - LO;
    assign hit[g] = (rel <= SPAN);
  end

  always_comb begin
    hit_o   = |hit;
    idx_o   = '0;
    local_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        idx_o   = IDX_W'(i);
        local_o = addr_i - reg_lo(i);
      end
    end
  end
endmodule

// File: rtl/region_map.sv
module region_map
  import page_mapper_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int MW    = MODE_W,
  parameter int IDX_W = REG_IDX_W
) (
  input  logic [MW-1:0]    mode_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  output tgt_e             tgt_o,
  output logic [AW-1:0]    base_o
);
  localparam int NMODE = 1 << MW;
  localparam logic [AW-1:0] HALF = AW'(1) << (AW-1);

  logic [NMODE-1:0] m;
  assign m = NMODE'(1) << mode_i;

  logic [AW-1:0] ident;
  always_comb ident = reg_lo(int'(idx_i));

  always_comb begin
    tgt_o  = TGT_RAM;
    base_o = ident;
    if (!hit_i) begin
      tgt_o  = TGT_NONE;
      base_o = '0;
    end else begin
      // RAM half swap covers every region below the I/O hole
      if (m[7] && idx_i < IDX_W'(10)) base_o = ident ^ HALF;
      unique case (idx_i)
        IDX_W'(0): if (m[0]) begin tgt_o = TGT_SYSROM; base_o = '0; end
        IDX_W'(2): if (m[10]) begin tgt_o = TGT_WIN1; base_o = '0; end
        IDX_W'(4): begin
          if (m[5] | m[10])     begin tgt_o = TGT_WIN2; base_o = '0; end
          else if (m[8] | m[9]) begin tgt_o = TGT_WIN1; base_o = '0; end
        end
        IDX_W'(5): begin
          if (m[5] | m[10])     begin tgt_o = TGT_WIN2;   base_o = '0; end
          else if (m[6] | m[8]) begin tgt_o = TGT_SYSROM; base_o = 16'h2000; end
        end
        IDX_W'(6): begin
          if (m[4] | m[5] | m[10]) begin tgt_o = TGT_WIN2;   base_o = 16'h1800; end
          else if (m[6] | m[8])    begin tgt_o = TGT_SYSROM; base_o = 16'h3800; end
        end
        IDX_W'(7): if (m[8] | m[10]) begin tgt_o = TGT_SYSROM; base_o = '0; end
        IDX_W'(8): begin
          if (m[8] | m[9]) begin tgt_o = TGT_WIN2;   base_o = '0; end
          else if (m[10])  begin tgt_o = TGT_SYSROM; base_o = 16'h0800; end
        end
        IDX_W'(9): if (m[8] | m[9]) begin tgt_o = TGT_WIN2; base_o = 16'h0800; end
        IDX_W'(10): begin tgt_o = TGT_IO; base_o = '0; end
        IDX_W'(11): begin
          tgt_o  = m[1] ? TGT_SYSROM : TGT_WIN1;
          base_o = '0;
        end
        IDX_W'(12): begin
          tgt_o  = (m[3] | m[4] | m[5]) ? TGT_WIN1 : TGT_SYSROM;
          base_o = 16'h0800;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import page_mapper_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        page_we_i,
  input  logic [3:0]  page_data_i,
  input  logic [15:0] addr_i,
  output logic [2:0]  tgt_o,
  output logic [15:0] offset_o,
  output logic        wr_en_o
);
  logic [MODE_W-1:0]    mode_q;
  logic                 hit;
  logic [REG_IDX_W-1:0] idx;
  logic [ADDR_W-1:0]    local_off;
  logic [ADDR_W-1:0]    base;
  tgt_e                 tgt;

  page_reg #(.MODE_W(MODE_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (page_we_i),
    .data_i (page_data_i),
    .mode_o (mode_q)
  );

  region_decode u_dec (
    .addr_i  (addr_i),
    .hit_o   (hit),
    .idx_o   (idx),
    .local_o (local_off)
  );

  region_map u_map (
    .mode_i (mode_q),
    .hit_i  (hit),
    .idx_i  (idx),
    .tgt_o  (tgt),
    .base_o (base)
  );

  assign tgt_o    = tgt;
  assign offset_o = hit ? base + local_off : '0;
  assign wr_en_o  = (tgt == TGT_RAM);
endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        page_we_i,
  input logic [3:0]  page_data_i,
  input logic [15:0] addr_i,
  input logic [2:0]  tgt_o,
  input logic [15:0] offset_o,
  input logic        wr_en_o,
  input logic [3:0]  mode_q
);
  AST_WR_ONLY_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> tgt_o == 3'd1) else $error("write enabled off RAM"); // R13

  AST_PAGE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_we_i |=> mode_q == $past(page_data_i)) else $error("page load"); // R2

  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_we_i |=> $stable(mode_q)) else $error("page hold"); // R2

  AST_HOLE_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i >= 16'hD800 && addr_i <= 16'hDBFF) || (addr_i >= 16'hDE00 && addr_i <= 16'hDFFF))
      |-> (tgt_o == 3'd0 && offset_o == 16'h0 && !wr_en_o)) else $error("hole"); // R12

  AST_IO_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= 16'hDC00 && addr_i <= 16'hDDFF)
      |-> (tgt_o == 3'd5 && !wr_en_o && offset_o == addr_i - 16'hDC00)) else $error("io"); // R11

  AST_TOP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i >= 16'hE000 |-> !wr_en_o) else $error("top write"); // R10

  AST_SWAP_HALVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'd7 && addr_i < 16'hD800)
      |-> (tgt_o == 3'd1 && offset_o == (addr_i ^ 16'h8000))) else $error("swap"); // R4
endmodule

bind page_mapper page_mapper_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .page_we_i   (page_we_i),
  .page_data_i (page_data_i),
  .addr_i      (addr_i),
  .tgt_o       (tgt_o),
  .offset_o    (offset_o),
  .wr_en_o     (wr_en_o),
  .mode_q      (mode_q)
);

// File: tb/page_mapper_bench.sv
module page_mapper_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        page_we_i = 1'b0;
  logic [3:0]  page_data_i = '0;
  logic [15:0] addr_i = '0;
  logic [2:0]  tgt_o;
  logic [15:0] offset_o;
  logic        wr_en_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int ref_mode = 0;
  bit strobe_prev = 0;

  always #10 clk_i = ~clk_i;

  page_mapper u_page_mapper (.*);

  // model mode register
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_mode    <= 0;
      strobe_prev <= 0;
    end else begin
      strobe_prev <= page_we_i;
      if (page_we_i) ref_mode <= int'(page_data_i);
    end
  end

  task automatic model(input int md, input int a,
                       output int t, output int o, output string tag);
    t = 1; o = a; tag = "R3";
    if ((a >= 'hD800 && a <= 'hDBFF) || (a >= 'hDE00 && a <= 'hDFFF)) begin
      t = 0; o = 0; tag = "R12";
    end else if (a >= 'hDC00 && a <= 'hDDFF) begin
      t = 5; o = a - 'hDC00; tag = "R11";
    end else if (a >= 'hE800) begin
      t = (md == 3 || md == 4 || md == 5) ? 3 : 2; o = a - 'hE000; tag = "R10";
    end else if (a >= 'hE000) begin
      t = (md == 1) ? 2 : 3; o = a - 'hE000; tag = "R9";
    end else if (md == 7) begin
      o = a ^ 'h8000; tag = "R4";
    end else if (a < 'h0800) begin
      if (md == 0) begin t = 2; tag = "R1"; end
    end else if (a >= 'h4000 && a < 'h6000) begin
      if (md == 10) begin t = 3; o = a - 'h4000; tag = "R7"; end
    end else if (a >= 'h8000 && a < 'hA000) begin
      if (md == 5 || md == 10)     begin t = 4; o = a - 'h8000; tag = "R6"; end
      else if (md == 8 || md == 9) begin t = 3; o = a - 'h8000; tag = "R7"; end
    end else if (a >= 'hA000 && a < 'hB800) begin
      if (md == 5 || md == 10)     begin t = 4; o = a - 'hA000; tag = "R6"; end
      else if (md == 6 || md == 8) begin t = 2; o = a - 'h8000; tag = "R5"; end
    end else if (a >= 'hB800 && a < 'hC000) begin
      if (md == 4 || md == 5 || md == 10) begin t = 4; o = a - 'hA000; tag = "R6"; end
      else if (md == 6 || md == 8)        begin t = 2; o = a - 'h8000; tag = "R5"; end
    end else if (a >= 'hC000 && a < 'hC800) begin
      if (md == 8 || md == 10) begin t = 2; o = a - 'hC000; tag = "R8"; end
    end else if (a >= 'hC800 && a < 'hD000) begin
      if (md == 8 || md == 9) begin t = 4; o = a - 'hC800; tag = "R6"; end
      else if (md == 10)      begin t = 2; o = a - 'hC000; tag = "R8"; end
    end else if (a >= 'hD000 && a < 'hD800) begin
      if (md == 8 || md == 9) begin t = 4; o = a - 'hC800; tag = "R6"; end
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk_i) begin
    if (!done) begin
      int t, o; string tag;
      model(ref_mode, int'(addr_i), t, o, tag);
      if (strobe_prev) tag = {"R2/", tag};
      n_run++;
      if (int'(tgt_o) != t || int'(offset_o) != o) begin
        n_fail++;
        $display("FAIL %s mode=%0d addr=%h: tgt=%0d off=%h expected tgt=%0d off=%h",
                 tag, ref_mode, addr_i, tgt_o, offset_o, t, o[15:0]);
      end
      n_run++;
      if (wr_en_o != (t == 1)) begin
        n_fail++;
        $display("FAIL R13 mode=%0d addr=%h: wr_en=%0b expected %0b",
                 ref_mode, addr_i, wr_en_o, (t == 1));
      end
    end
  end

  localparam int NA = 33;
  localparam logic [15:0] ADDRS [NA] = '{
    16'h0000, 16'h07FF, 16'h0800, 16'h3FFF, 16'h4000, 16'h5FFF, 16'h6000, 16'h7FFF,
    16'h8000, 16'h9FFF, 16'hA000, 16'hB7FF, 16'hB800, 16'hBFFF, 16'hC000, 16'hC7FF,
    16'hC800, 16'hCFFF, 16'hD000, 16'hD7FF, 16'hD800, 16'hDBFF, 16'hDC00, 16'hDDFF,
    16'hDE00, 16'hDFFF, 16'hE000, 16'hE7FF, 16'hE800, 16'hFFFF, 16'h1234, 16'hA5A5,
    16'hF00D};

  task automatic cyc(input logic we, input logic [3:0] d, input logic [15:0] a);
    @(posedge clk_i); #1;
    page_we_i = we; page_data_i = d; addr_i = a;
  endtask

  initial begin
    // R1: reset state, mode 0 during reset
    addr_i = 16'h0123;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    cyc(1'b0, 4'd9, 16'h07FF);   // data ignored without strobe (R2)
    cyc(1'b0, 4'd9, 16'h0000);
    for (int md = 0; md < 16; md++) begin
      cyc(1'b1, 4'(md), 16'h0000);   // strobe cycle uses previous mode
      cyc(1'b0, 4'(15 - md), 16'h0000); // first cycle in new mode
      for (int k = 0; k < NA; k++) cyc(1'b0, 4'(k), ADDRS[k]);
    end
    // back-to-back strobes
    cyc(1'b1, 4'd7, 16'h8000);
    cyc(1'b1, 4'd10, 16'h8000);
    cyc(1'b1, 4'd1, 16'h8000);
    cyc(1'b0, 4'd0, 16'hE000);
    // asynchronous reset back to mode 0
    @(posedge clk_i); #1 addr_i = 16'h0400;
    #4 rst_ni = 1'b0;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    cyc(1'b0, 4'd0, 16'h0400);
    cyc(1'b0, 4'd0, 16'hE000);
    @(negedge clk_i); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule